// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Command Engine

This block is the serial-side controller of a 2048 x 8 byte-addressable non-volatile memory model. It listens to an SPI bus (clock modes 0 and 3), decodes a one-byte command and then runs one of six transactions: array read, array write, status read, status write, write-enable and write-disable. All bus pins are brought into the system clock domain and their edges are detected there, so the block is fully synchronous to `clk` and the system clock must run several times faster than SCK.

Array writes are collected in a page buffer of `PAGE` bytes (16 or 32). They are copied into the array only when chip select rises exactly on a byte boundary. A separate protection unit owns the write timer and the protection decision. It sees the write-enable latch, the non-volatile status bits and the start address of a pending write. It answers with two permit inputs and a busy input, and it starts its timer on the one-cycle `start_wr_o` pulse. A hold input pauses a transaction in mid-flight without losing its place.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Opcodes are WRSR 0x01, WRITE 0x02, READ 0x03, WRDI 0x04, RDSR 0x05 and WREN 0x06. Every field is sent most significant bit first. SI is captured on rising SCK and SO is updated after falling SCK, and the same bytes result whether SCK idles low (mode 0) or high (mode 3).
- R2: READ and WRITE are followed by two address bytes, high byte first, of which only the low 11 bits are used. READ then returns the byte at that address and continues with the next address for every further byte. Address 0x7FF is followed by 0x000.
- R3: A WRITE whose data bytes are all complete commits when CS rises, provided the write-enable latch is set, `arr_permit_i` is high and the block is not busy. The bytes land at the start address onward, `start_wr_o` pulses once, `wr_addr_o` shows the start address and the latch clears.
- R4: A write that runs past the end of its page (PAGE bytes, aligned) continues at the first byte of the same page and overwrites bytes already sent in that transaction.
- R5: A WRITE ended while a data byte is incomplete, or ended before any data byte, stores nothing, gives no `start_wr_o` pulse and leaves the write-enable latch as it was.
- R6: WREN sets and WRDI clears the write-enable latch only when CS rises after exactly eight SCK bits. Seven or nine bits leave the latch unchanged.
- R7: RDSR returns, and keeps repeating, the status byte: bit 7 = protect-pin enable, bits 6:4 = 0, bits 3:2 = block-protect level, bit 1 = write-enable latch, bit 0 = write in progress. It is served while busy.
- R8: WRSR with one complete data byte copies data bits 7, 3 and 2 into the status bits `prot_cfg_o` = {bit 7, bit 3, bit 2}, clears the latch and pulses `start_wr_o`, but only with the latch set, `sr_permit_i` high and the block not busy. Otherwise it changes nothing.
- R9: While busy (`busy_i` high or the page buffer still draining) every opcode except RDSR is ignored: reads keep SO in high impedance, and writes and latch commands have no effect.
- R10: `so_oe` is low whenever CS is high and for the whole of a transaction whose opcode is undefined.
- R11: HOLD low, when seen with SCK low, pauses the transaction: `so_oe` drops and SCK and SI edges are ignored. HOLD high with SCK low resumes the transaction at the exact bit where it stopped.
- R12: A complete WRITE with `arr_permit_i` low stores nothing, gives no pulse and leaves the write-enable latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| busy_i | input | 1 | Write timer of the protection unit running |
| arr_permit_i | input | 1 | Protection unit allows the pending array write |
| sr_permit_i | input | 1 | Protection unit allows the pending status write |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| start_wr_o | output | 1 | One-cycle pulse when a write commits |
| wr_addr_o | output | $clog2(DEPTH) | Start address of the current or last write |
| prot_cfg_o | output | 3 | Non-volatile status bits {pin enable, level[1:0]} |
| wel_o | output | 1 | Write-enable latch |

## Verification
The hardest state to reach from the pins is a hold that lands in the middle of a read byte. The output shifter, the read pointer and the bit counter must all survive a burst of ignored SCK edges and then resume on the correct bit. The bench reaches it with a bit-level master: it stops after three bits of a data byte, lowers HOLD while SCK is low, toggles SCK several times and releases HOLD before it finishes that byte and the next. The discard cases use the same master to raise chip select after a stray partial byte or an extra ninth bit, and then read the array and status back to prove that nothing changed.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [3:0] {
    PH_OPC, PH_AHI, PH_ALO, PH_RDAT, PH_WDAT, PH_RSR,
    PH_WSR, PH_WSR_END, PH_EN_END, PH_DIS_END, PH_SKIP
  } phase_e;
endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], pin_i[g]};
    end
    assign lvl_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/ee_hold_gate.sv
module ee_hold_gate (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic hold_lvl,
  input  logic sck_lvl,
  input  logic sck_rise,
  input  logic sck_fall,
  output logic paused,
  output logic rise_ok,
  output logic fall_ok
);
  always_ff @(posedge clk) begin
    if (rst || !sel)                   paused <= 1'b0;
    else if (!paused)                  paused <= !hold_lvl && !sck_lvl;
    else if (hold_lvl && !sck_lvl)     paused <= 1'b0;
  end

  // a falling edge seen together with a low hold is the one that enters the pause
  assign rise_ok = sel && !paused && sck_rise;
  assign fall_ok = sel && !paused && hold_lvl && sck_fall;
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE = 16,
  parameter int AW = 11,
  localparam int PW = $clog2(PAGE)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_off,
  input  logic [7:0]      wr_data,
  input  logic            start,
  input  logic [AW-PW-1:0] page_base,
  output logic            draining,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata
);
  logic [7:0]       lat [PAGE];
  logic [PAGE-1:0]  vld;
  logic [PW-1:0]    idx;
  logic [AW-PW-1:0] page_q;

  always_ff @(posedge clk) begin
    if (wr_en) lat[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) vld <= '0;
    else if (wr_en)   vld[wr_off] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      draining <= 1'b0;
      idx      <= '0;
      page_q   <= '0;
    end else if (start) begin
      draining <= 1'b1;
      idx      <= '0;
      page_q   <= page_base;
    end else if (draining) begin
      idx <= idx + 1'b1;
      if (idx == PW'(PAGE - 1)) draining <= 1'b0;
    end
  end

  assign mem_we    = draining && vld[idx];
  assign mem_addr  = {page_q, idx};
  assign mem_wdata = lat[idx];
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spiee_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int PAGE = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sck,
  input  logic                     cs_n,
  input  logic                     si,
  input  logic                     hold_n,
  input  logic                     busy_i,
  input  logic                     arr_permit_i,
  input  logic                     sr_permit_i,
  output logic                     so,
  output logic                     so_oe,
  output logic                     start_wr_o,
  output logic [$clog2(DEPTH)-1:0] wr_addr_o,
  output logic [2:0]               prot_cfg_o,
  output logic                     wel_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam int HW = AW - 8;  // address bits carried by the high address byte

  logic [3:0] lvl;
  logic       sck_d, cs_d, sel, cs_rise, sck_rise, sck_fall;
  logic       paused, rise_ok, fall_ok;

  ee_pin_sync #(.N(4), .STAGES(2), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst(rst), .pin_i({hold_n, cs_n, si, sck}), .lvl_o(lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= lvl[0];
      cs_d  <= lvl[2];
    end
  end

  assign sel      = !lvl[2];
  assign cs_rise  = lvl[2] && !cs_d;
  assign sck_rise = lvl[0] && !sck_d;
  assign sck_fall = !lvl[0] && sck_d;

  ee_hold_gate u_hold (
    .clk(clk), .rst(rst), .sel(sel), .hold_lvl(lvl[3]), .sck_lvl(lvl[0]),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .paused(paused), .rise_ok(rise_ok), .fall_ok(fall_ok));

  phase_e         ph;
  logic [2:0]     bcnt, tcnt;
  logic [7:0]     sh, txb, rdata, status, byte_in, src;
  logic [HW-1:0]  ahi;
  logic [AW-1:0]  ptr, full_addr;
  logic [PW-1:0]  woff;
  logic           is_wr, got, wel, start_q, so_q, oe_q;
  logic [2:0]     nv;
  logic           draining, busy_eff, mem_we;
  logic [AW-1:0]  mem_addr;
  logic [7:0]     mem_wdata;
  logic           commit_arr, commit_sr, byte_end, pb_wr, pb_clear;

  assign busy_eff   = busy_i || draining;
  assign byte_in    = {sh[6:0], lvl[1]};
  assign byte_end   = rise_ok && (bcnt == 3'd7);
  assign full_addr  = {ahi, byte_in};
  assign status     = {nv[2], 3'b000, nv[1:0], wel, busy_eff};
  assign src        = (ph == PH_RDAT) ? rdata : status;
  assign pb_wr      = byte_end && (ph == PH_WDAT);
  assign pb_clear   = byte_end && (ph == PH_ALO) && is_wr;
  assign commit_arr = cs_rise && (ph == PH_WDAT) && got && (bcnt == 3'd0) &&
                      wel && arr_permit_i && !busy_eff;
  assign commit_sr  = cs_rise && (ph == PH_WSR_END) && wel && sr_permit_i && !busy_eff;

  ee_page_buf #(.PAGE(PAGE), .AW(AW)) u_page (
    .clk(clk), .rst(rst), .clear(pb_clear), .wr_en(pb_wr), .wr_off(woff),
    .wr_data(byte_in), .start(commit_arr), .page_base(ptr[AW-1:PW]),
    .draining(draining), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  ee_array #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_OPC; bcnt <= '0; tcnt <= '0; sh <= '0; txb <= '0; ahi <= '0;
      ptr <= '0; woff <= '0; is_wr <= 1'b0; got <= 1'b0; wel <= 1'b0;
      nv <= '0; start_q <= 1'b0; so_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      start_q <= commit_arr || commit_sr;
      oe_q    <= sel && !paused && (ph == PH_RDAT || ph == PH_RSR);
      if (!sel) begin
        ph <= PH_OPC; bcnt <= '0; tcnt <= '0; got <= 1'b0;
      end
      if (cs_rise) begin
        if (ph == PH_EN_END)  wel <= 1'b1;
        if (ph == PH_DIS_END) wel <= 1'b0;
        if (commit_sr) begin
          nv  <= {sh[7], sh[3:2]};
          wel <= 1'b0;
        end
        if (commit_arr) wel <= 1'b0;
      end else if (rise_ok) begin
        sh   <= byte_in;
        bcnt <= bcnt + 1'b1;
        if (ph inside {PH_EN_END, PH_DIS_END, PH_WSR_END}) ph <= PH_SKIP;
        if (bcnt == 3'd7) begin
          case (ph)
            PH_OPC: begin
              if (busy_eff && byte_in != OP_RDSR) ph <= PH_SKIP;
              else case (byte_in)
                OP_READ:  begin ph <= PH_AHI; is_wr <= 1'b0; end
                OP_WRITE: begin ph <= PH_AHI; is_wr <= 1'b1; end
                OP_WREN:  ph <= PH_EN_END;
                OP_WRDI:  ph <= PH_DIS_END;
                OP_RDSR:  ph <= PH_RSR;
                OP_WRSR:  ph <= PH_WSR;
                default:  ph <= PH_SKIP;
              endcase
            end
            PH_AHI: begin
              ahi <= byte_in[HW-1:0];
              ph  <= PH_ALO;
            end
            PH_ALO: begin
              ptr  <= full_addr;
              woff <= full_addr[PW-1:0];
              ph   <= is_wr ? PH_WDAT : PH_RDAT;
            end
            PH_WDAT: begin
              got  <= 1'b1;
              woff <= woff + 1'b1;
            end
            PH_WSR:  ph <= PH_WSR_END;
            default: ;
          endcase
        end
      end else if (fall_ok && (ph == PH_RDAT || ph == PH_RSR)) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == 3'd0) begin
          so_q <= src[7];
          txb  <= {src[6:0], 1'b0};
          if (ph == PH_RDAT) ptr <= ptr + 1'b1;
        end else begin
          so_q <= txb[7];
          txb  <= {txb[6:0], 1'b0};
        end
      end
    end
  end

  assign so         = so_q;
  assign so_oe      = oe_q;
  assign start_wr_o = start_q;
  assign wr_addr_o  = ptr;
  assign prot_cfg_o = nv;
  assign wel_o      = wel;
endmodule

// File: rtl/spiee_checker.sv
module spiee_checker (
  input logic clk,
  input logic rst,
  input logic sel,
  input logic paused,
  input logic cs_rise,
  input logic so_oe,
  input logic start_wr,
  input logic busy_i,
  input logic wel
);
  // R10
  idle_hiz_chk: assert property (@(posedge clk) disable iff (rst) !sel |=> !so_oe);
  // R11
  held_hiz_chk: assert property (@(posedge clk) disable iff (rst) paused |=> !so_oe);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst) start_wr |=> !start_wr);
  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (rst) start_wr |-> $past(!busy_i));
  // R6
  wel_set_chk: assert property (@(posedge clk) disable iff (rst) $rose(wel) |-> $past(cs_rise));
endmodule

bind spi_eeprom_slave spiee_checker u_chk (
  .clk(clk), .rst(rst), .sel(sel), .paused(paused), .cs_rise(cs_rise),
  .so_oe(so_oe), .start_wr(start_wr_o), .busy_i(busy_i), .wel(wel_o));

// File: tb/test_spi_eeprom_slave.sv
module test_spi_eeprom_slave;
  localparam int DEPTH = 2048;
  localparam int PAGE = 16;
  localparam int H = 8;
  localparam int BUSY_CYC = 2000;

  logic clk = 0, rst = 1, sck = 0, cs_n = 1, si = 0, hold_n = 1;
  logic arr_permit = 1, sr_permit = 1, busy_i;
  logic so, so_oe, start_wr, wel;
  logic [10:0] wr_addr;
  logic [2:0] prot_cfg;
  int n_chk = 0, n_bad = 0, bcnt_m = 0;
  bit mode3 = 0;
  logic [7:0] refm [DEPTH];
  logic [7:0] wbuf [32];

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst) bcnt_m <= 0;
    else if (start_wr) bcnt_m <= BUSY_CYC;
    else if (bcnt_m != 0) bcnt_m <= bcnt_m - 1;
  end
  assign busy_i = (bcnt_m != 0);

  spi_eeprom_slave #(.DEPTH(DEPTH), .PAGE(PAGE)) i_spi_eeprom_slave (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .busy_i(busy_i), .arr_permit_i(arr_permit), .sr_permit_i(sr_permit),
    .so(so), .so_oe(so_oe), .start_wr_o(start_wr), .wr_addr_o(wr_addr),
    .prot_cfg_o(prot_cfg), .wel_o(wel));

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic spi_bit(input logic b, output logic r);
    if (mode3) sck = 0;
    si = b;
    wclk(H);
    r = so;
    sck = 1;
    wclk(H);
    if (!mode3) sck = 0;
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(b[i], r[i]);
  endtask

  task automatic cs_on();
    sck = mode3;
    wclk(H);
    cs_n = 0;
    wclk(H);
  endtask

  task automatic cs_off();
    wclk(H);
    cs_n = 1;
    wclk(2 * H);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_on(); spi_byte(op, r); cs_off();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    cs_on(); spi_byte(8'h05, r); spi_byte(8'h00, st); cs_off();
  endtask

  task automatic wait_idle();
    while (busy_i) wclk(1);
    wclk(40);
  endtask

  // sends a WRITE with n bytes from wbuf; the reference array is updated when a commit is expected
  task automatic write_tx(input logic [15:0] a, input int n, input bit upd);
    logic [7:0] r;
    cs_on();
    spi_byte(8'h02, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      spi_byte(wbuf[i], r);
      if (upd) refm[{a[10:4], 4'((a[3:0] + i) % PAGE)}] = wbuf[i];
    end
    cs_off();
  endtask

  task automatic wr_full(input logic [15:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) wbuf[i] = seed + 8'(i * 7);
    cmd1(8'h06);
    write_tx(a, n, 1);
    wait_idle();
  endtask

  task automatic read_check(input string req, input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_on();
    spi_byte(8'h03, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, r);
      chk(req, r, refm[11'((a[10:0] + i) % DEPTH)]);
    end
    cs_off();
  endtask

  task automatic t_reset();
    logic [7:0] st;
    chk("R10 so_oe after reset", so_oe, 0);
    chk("R6 wel after reset", wel, 0);
    chk("R8 prot_cfg after reset", prot_cfg, 0);
    rdsr(st);
    chk("R7 status after reset", st, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] st;
    cmd1(8'h06);
    rdsr(st);
    chk("R6 WREN sets latch", st, 8'h02);
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    write_tx(16'hF923, 3, 1);
    chk("R3 write starts timer", busy_i, 1);
    chk("R3 wr_addr start address", wr_addr, 11'h123);
    rdsr(st);
    chk("R7 status during busy, R3 latch cleared", st, 8'h01);
    wait_idle();
    read_check("R3 R2 read back mode 0", 16'h0123, 3);
    mode3 = 1;
    read_check("R1 read back mode 3", 16'h0123, 3);
    rdsr(st);
    chk("R1 RDSR mode 3", st, 8'h00);
    mode3 = 0;
  endtask

  task automatic t_rollover();
    wr_full(16'h07FE, 2, 8'h30);
    wr_full(16'h0000, 2, 8'h40);
    read_check("R2 rollover 0x7FF to 0x000", 16'h07FE, 4);
  endtask

  task automatic t_pagewrap();
    wr_full(16'h0200, 16, 8'h01);
    wr_full(16'h0205, 14, 8'h90);
    read_check("R4 page wrap", 16'h0200, 16);
  endtask

  task automatic t_partial();
    logic [7:0] r, st;
    logic b;
    wr_full(16'h0150, 1, 8'h3C);
    cmd1(8'h06);
    cs_on();
    spi_byte(8'h02, r); spi_byte(8'h01, r); spi_byte(8'h50, r);
    spi_byte(8'h5A, r);
    spi_bit(1'b1, b); spi_bit(1'b0, b); spi_bit(1'b1, b);
    cs_off();
    chk("R5 partial byte no timer", busy_i, 0);
    rdsr(st);
    chk("R5 partial byte keeps latch", st, 8'h02);
    write_tx(16'h0150, 0, 0);
    chk("R5 no data byte no timer", busy_i, 0);
    read_check("R5 partial write discarded", 16'h0150, 1);
    cmd1(8'h04);
    rdsr(st);
    chk("R6 WRDI clears latch", st, 8'h00);
  endtask

  task automatic t_wren_len();
    logic [7:0] r, st;
    logic b;
    cs_on(); spi_byte(8'h06, r); spi_bit(1'b0, b); cs_off();
    rdsr(st);
    chk("R6 WREN with nine bits ignored", st, 8'h00);
    cs_on();
    for (int i = 7; i >= 1; i--) spi_bit(i == 1 || i == 2, b);
    cs_off();
    rdsr(st);
    chk("R6 WREN with seven bits ignored", st, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] r, st;
    logic b;
    cmd1(8'h06);
    wbuf[0] = 8'h11;
    write_tx(16'h0300, 1, 1);
    chk("R9 timer running", busy_i, 1);
    cs_on();
    spi_byte(8'h03, r); spi_byte(8'h01, r); spi_byte(8'h23, r);
    spi_bit(1'b0, b); spi_bit(1'b0, b);
    chk("R9 read while busy stays high impedance", so_oe, 0);
    cs_off();
    cmd1(8'h06);
    wait_idle();
    rdsr(st);
    chk("R9 WREN while busy ignored", st, 8'h00);
    read_check("R9 read after busy", 16'h0300, 1);
  endtask

  task automatic t_protect();
    logic [7:0] st;
    wr_full(16'h0400, 1, 8'h55);
    arr_permit = 0;
    cmd1(8'h06);
    wbuf[0] = 8'h66;
    write_tx(16'h0400, 1, 0);
    chk("R12 refused write no timer", busy_i, 0);
    rdsr(st);
    chk("R12 refused write keeps latch", st, 8'h02);
    arr_permit = 1;
    read_check("R12 refused write discarded", 16'h0400, 1);
    cmd1(8'h04);
  endtask

  task automatic t_wrsr();
    logic [7:0] r, st;
    cmd1(8'h06);
    cs_on(); spi_byte(8'h01, r); spi_byte(8'h8C, r); cs_off();
    rdsr(st);
    chk("R8 WRSR status during write", st, 8'h8D);
    wait_idle();
    chk("R8 prot_cfg updated", prot_cfg, 3'b111);
    sr_permit = 0;
    cmd1(8'h06);
    cs_on(); spi_byte(8'h01, r); spi_byte(8'h00, r); cs_off();
    chk("R8 refused WRSR no timer", busy_i, 0);
    rdsr(st);
    chk("R8 refused WRSR keeps bits and latch", st, 8'h8E);
    sr_permit = 1;
    cs_on(); spi_byte(8'h01, r); spi_byte(8'h00, r); cs_off();
    wait_idle();
    chk("R8 prot_cfg cleared again", prot_cfg, 3'b000);
  endtask

  task automatic t_undef();
    logic [7:0] r;
    cs_on();
    spi_byte(8'hAA, r);
    wclk(4);
    chk("R10 undefined opcode high impedance", so_oe, 0);
    spi_byte(8'h00, r);
    chk("R10 undefined opcode stays high impedance", so_oe, 0);
    cs_off();
    chk("R10 CS high high impedance", so_oe, 0);
  endtask

  task automatic t_hold();
    logic [7:0] r, d;
    logic b;
    cs_on();
    spi_byte(8'h03, r); spi_byte(8'h01, r); spi_byte(8'h23, r);
    for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, b); d[i] = b; end
    wclk(H);
    hold_n = 0;
    wclk(H);
    chk("R11 hold tri-states SO", so_oe, 0);
    for (int k = 0; k < 4; k++) begin
      si = k[0]; sck = 1; wclk(H); sck = 0; wclk(H);
    end
    chk("R11 SO stays off while held", so_oe, 0);
    hold_n = 1;
    wclk(H);
    for (int i = 4; i >= 0; i--) begin spi_bit(1'b0, b); d[i] = b; end
    chk("R11 byte resumes after hold", d, refm[11'h123]);
    spi_byte(8'h00, r);
    chk("R11 next byte after hold", r, refm[11'h124]);
    cs_off();
  endtask

  initial begin
    wclk(10);
    rst = 0;
    wclk(10);
    t_reset();
    t_basic();
    t_rollover();
    t_pagewrap();
    t_partial();
    t_wren_len();
    t_busy();
    t_protect();
    t_wrsr();
    t_undef();
    t_hold();
    report();
  end

  initial begin
    wclk(190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    report();
  end
endmodule